// File: doc/BRIEF.md
# Address Translation Window Unit

This block maps addresses between an on-chip interconnect (36-bit addresses) and a serial packet fabric (34-bit addresses) through a small set of programmable windows. Each window holds a base, a power-of-two size, a translation address, an enable bit and a set of attributes. In the outbound direction a window may also be flagged to recast reads and writes as maintenance requests. One instance serves one direction. A parameter picks the direction, and with it the input and output widths and the largest legal window.

A lookup is purely combinational. The input address is compared against every enabled window at once. The lowest-numbered hit is selected. The address bits above the window size come from that window's translation address, and the bits below it pass through unchanged. When no window hits, window 0's settings are used. A single write port loads a whole window in one cycle, and the lookup sees the new contents from the following cycle.

Top module: `atw_xlate`

## Requirements
- R1: When no enabled window contains the address, `lk_hit` is 0, `lk_win` is 0, and the output address and attributes come from window 0's registers.
- R2: When several enabled windows contain the address, the one with the smallest index is selected and reported on `lk_win`, with `lk_hit` = 1.
- R3: The size code is log2(window bytes) − 1. A code below 11 (4 KB) is stored as 11. A code above the direction's maximum (33 inbound = 16 GB, 35 outbound = 64 GB) is stored as that maximum. `wr_size_err` is 1 in exactly the cycles in which `wr_en` is 1 with such an out-of-range code.
- R4: Output address bits below code+1 equal the input bits, and bits above come from the selected window's translation address. The low 12 bits always pass through.
- R5: Inbound (OUTBOUND=0) takes a 34-bit address and produces a 36-bit one, and outbound takes 36 bits to 34 bits. A window contains an address when all input bits at or above code+1 equal the base's bits.
- R6: After reset an inbound unit's window 0 is enabled with code 33 and translation 0, so every address comes out unchanged, zero-extended, with hit 1 and window 0.
- R7: After reset an outbound unit's window 0 is enabled with code 35 and translation 0, so the output is the low 34 bits of the input. Windows 1 and above reset disabled in both directions.
- R8: In an outbound unit, a lookup that selects a window written with `wr_maint` = 1 drives `lk_maint` = 1 together with that window's hop count, source ID, destination ID, priority and configuration offset. An inbound unit never drives `lk_maint` to 1.
- R9: A window whose enable is 0 never produces a hit, whatever its base and size.
- R10: A write with `wr_en` = 1 changes the window at the next rising clock edge. A lookup in the write cycle uses the old contents.
- R11: The priority, hop, ID and offset outputs are those of the selected window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe: load window `wr_idx` |
| wr_idx | input | IDX_W (2) | Window to write |
| wr_base | input | SRC_AW (34/36) | Window base, in input address space |
| wr_xlat | input | DST_AW (36/34) | Translation address, in output space |
| wr_szenc | input | 6 | Size code, log2(bytes) − 1 |
| wr_ena | input | 1 | Window enable |
| wr_maint | input | 1 | Maintenance window (outbound only) |
| wr_hops | input | HOP_W (8) | Hop count attribute |
| wr_src | input | ID_W (16) | Source ID attribute |
| wr_dst | input | ID_W (16) | Destination ID attribute |
| wr_prio | input | 2 | Priority attribute |
| wr_cfgoff | input | OFF_W (24) | Configuration offset attribute |
| wr_size_err | output | 1 | Write carries an out-of-range size code |
| lk_addr | input | SRC_AW | Address to translate |
| lk_out | output | DST_AW | Translated address |
| lk_hit | output | 1 | Some enabled window contains the address |
| lk_win | output | IDX_W | Selected window |
| lk_maint | output | 1 | Access becomes a maintenance request |
| lk_hops | output | HOP_W | Selected hop count |
| lk_src | output | ID_W | Selected source ID |
| lk_dst | output | ID_W | Selected destination ID |
| lk_prio | output | 2 | Selected priority |
| lk_cfgoff | output | OFF_W | Selected configuration offset |

## Verification
On every cycle the assertions check three things: that a miss reports window 0, that the selected window hits while no lower-numbered one does, and that the low 12 address bits always pass through. They also check that a size error occurs only during a write. Some behaviours only the bench's scenarios can show, because they need a history of writes compared against a behavioural model: the reset defaults of each direction, the clamping of size codes, the one-cycle write latency, attributes and maintenance routing following the selected window, and disabled windows being skipped.

// File: rtl/atw_xlate.sv
`timescale 1ns/1ps
module atw_xlate #(
  parameter int NWIN     = 4,
  parameter bit OUTBOUND = 1'b1,
  parameter int FAB_AW   = 34,
  parameter int INT_AW   = 36,
  parameter int ID_W     = 16,
  parameter int HOP_W    = 8,
  parameter int OFF_W    = 24,
  localparam int IDX_W   = $clog2(NWIN),
  localparam int SRC_AW  = OUTBOUND ? INT_AW : FAB_AW,
  localparam int DST_AW  = OUTBOUND ? FAB_AW : INT_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [SRC_AW-1:0] wr_base,
  input  logic [DST_AW-1:0] wr_xlat,
  input  logic [5:0]        wr_szenc,
  input  logic              wr_ena,
  input  logic              wr_maint,
  input  logic [HOP_W-1:0]  wr_hops,
  input  logic [ID_W-1:0]   wr_src,
  input  logic [ID_W-1:0]   wr_dst,
  input  logic [1:0]        wr_prio,
  input  logic [OFF_W-1:0]  wr_cfgoff,
  output logic              wr_size_err,
  input  logic [SRC_AW-1:0] lk_addr,
  output logic [DST_AW-1:0] lk_out,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_win,
  output logic              lk_maint,
  output logic [HOP_W-1:0]  lk_hops,
  output logic [ID_W-1:0]   lk_src,
  output logic [ID_W-1:0]   lk_dst,
  output logic [1:0]        lk_prio,
  output logic [OFF_W-1:0]  lk_cfgoff
);
  localparam logic [5:0] MIN_E = 6'd11;
  localparam logic [5:0] MAX_E = 6'(SRC_AW - 1);

  logic [SRC_AW-1:0] r_base  [NWIN];
  logic [DST_AW-1:0] r_xlat  [NWIN];
  logic [5:0]        r_enc   [NWIN];
  logic              r_ena   [NWIN];
  logic              r_maint [NWIN];
  logic [HOP_W-1:0]  r_hops  [NWIN];
  logic [ID_W-1:0]   r_src   [NWIN];
  logic [ID_W-1:0]   r_dst   [NWIN];
  logic [1:0]        r_prio  [NWIN];
  logic [OFF_W-1:0]  r_off   [NWIN];

  wire enc_lo = wr_szenc < MIN_E;
  wire enc_hi = wr_szenc > MAX_E;
  wire [5:0] enc_c = enc_lo ? MIN_E : (enc_hi ? MAX_E : wr_szenc);
  assign wr_size_err = wr_en && (enc_lo || enc_hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) begin
        r_base[i]  <= '0;
        r_xlat[i]  <= '0;
        r_enc[i]   <= MAX_E;
        r_ena[i]   <= (i == 0);
        r_maint[i] <= 1'b0;
        r_hops[i]  <= '0;
        r_src[i]   <= '0;
        r_dst[i]   <= '0;
        r_prio[i]  <= '0;
        r_off[i]   <= '0;
      end
    end else if (wr_en) begin
      r_base[wr_idx]  <= wr_base;
      r_xlat[wr_idx]  <= wr_xlat;
      r_enc[wr_idx]   <= enc_c;
      r_ena[wr_idx]   <= wr_ena;
      r_maint[wr_idx] <= wr_maint && OUTBOUND;
      r_hops[wr_idx]  <= wr_hops;
      r_src[wr_idx]   <= wr_src;
      r_dst[wr_idx]   <= wr_dst;
      r_prio[wr_idx]  <= wr_prio;
      r_off[wr_idx]   <= wr_cfgoff;
    end
  end

  logic [NWIN-1:0]   win_hit;
  logic [SRC_AW-1:0] w_mask [NWIN];

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    assign w_mask[g]  = ~({SRC_AW{1'b1}} << (r_enc[g] + 6'd1));
    assign win_hit[g] = r_ena[g] && (((lk_addr ^ r_base[g]) & ~w_mask[g]) == '0);
  end

  logic [IDX_W-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = NWIN - 1; i >= 0; i--)
      if (win_hit[i]) sel = IDX_W'(i);
  end

  wire [DST_AW-1:0] dmask = DST_AW'(w_mask[sel]);

  assign lk_hit    = |win_hit;
  assign lk_win    = sel;
  assign lk_out    = (r_xlat[sel] & ~dmask) | (DST_AW'(lk_addr) & dmask);
  assign lk_maint  = r_maint[sel];
  assign lk_hops   = r_hops[sel];
  assign lk_src    = r_src[sel];
  assign lk_dst    = r_dst[sel];
  assign lk_prio   = r_prio[sel];
  assign lk_cfgoff = r_off[sel];
endmodule

// File: rtl/atw_xlate_chk.sv
`timescale 1ns/1ps
module atw_xlate_chk #(
  parameter int NWIN   = 4,
  parameter int SRC_AW = 36,
  parameter int DST_AW = 34,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_size_err,
  input logic [SRC_AW-1:0] lk_addr,
  input logic [DST_AW-1:0] lk_out,
  input logic              lk_hit,
  input logic [IDX_W-1:0]  lk_win,
  input logic [NWIN-1:0]   win_hit
);
  a_r1_miss_win0: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_win == '0) && (win_hit == '0));

  a_r2_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> win_hit[lk_win] && ((win_hit & ((NWIN'(1) << lk_win) - NWIN'(1))) == '0));

  a_r4_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    lk_out[11:0] == lk_addr[11:0]);

  a_r3_err_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_size_err |-> wr_en);
endmodule

bind atw_xlate atw_xlate_chk #(.NWIN(NWIN), .SRC_AW(SRC_AW), .DST_AW(DST_AW), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_size_err(wr_size_err),
  .lk_addr(lk_addr), .lk_out(lk_out), .lk_hit(lk_hit), .lk_win(lk_win), .win_hit(win_hit)
);

// File: tb/tb_atw_xlate.sv
`timescale 1ns/1ps
module tb_atw_xlate;
  logic clk = 0;
  always #5 clk = ~clk;
  logic rst_n = 0;

  logic        wr_en_o = 0, wr_en_i = 0;
  logic [1:0]  wr_idx = 0;
  logic [35:0] wr_base = 0, wr_xlat = 0;
  logic [5:0]  wr_enc = 0;
  logic        wr_ena = 0, wr_maint = 0;
  logic [7:0]  wr_hops = 0;
  logic [15:0] wr_src = 0, wr_dst = 0;
  logic [1:0]  wr_prio = 0;
  logic [23:0] wr_off = 0;
  logic [35:0] la = 0;

  logic        o_err, o_hit, o_maint; logic [1:0] o_win, o_prio; logic [33:0] o_out;
  logic [7:0]  o_hops; logic [15:0] o_src, o_dst; logic [23:0] o_off;
  logic        i_err, i_hit, i_maint; logic [1:0] i_win, i_prio; logic [35:0] i_out;
  logic [7:0]  i_hops; logic [15:0] i_src, i_dst; logic [23:0] i_off;

  atw_xlate #(.OUTBOUND(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_o), .wr_idx(wr_idx), .wr_base(wr_base),
    .wr_xlat(wr_xlat[33:0]), .wr_szenc(wr_enc), .wr_ena(wr_ena), .wr_maint(wr_maint),
    .wr_hops(wr_hops), .wr_src(wr_src), .wr_dst(wr_dst), .wr_prio(wr_prio), .wr_cfgoff(wr_off),
    .wr_size_err(o_err), .lk_addr(la), .lk_out(o_out), .lk_hit(o_hit), .lk_win(o_win),
    .lk_maint(o_maint), .lk_hops(o_hops), .lk_src(o_src), .lk_dst(o_dst), .lk_prio(o_prio),
    .lk_cfgoff(o_off));

  atw_xlate #(.OUTBOUND(1'b0)) dut_in (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_idx(wr_idx), .wr_base(wr_base[33:0]),
    .wr_xlat(wr_xlat), .wr_szenc(wr_enc), .wr_ena(wr_ena), .wr_maint(wr_maint),
    .wr_hops(wr_hops), .wr_src(wr_src), .wr_dst(wr_dst), .wr_prio(wr_prio), .wr_cfgoff(wr_off),
    .wr_size_err(i_err), .lk_addr(la[33:0]), .lk_out(i_out), .lk_hit(i_hit), .lk_win(i_win),
    .lk_maint(i_maint), .lk_hops(i_hops), .lk_src(i_src), .lk_dst(i_dst), .lk_prio(i_prio),
    .lk_cfgoff(i_off));

  int checks = 0, errors = 0;
  string cur_req = "R6";

  // behavioural model: index 0 = inbound, 1 = outbound
  logic [35:0] mb [2][4], mx [2][4];
  int          me [2][4];
  bit          men [2][4], mm [2][4];
  logic [7:0]  mh [2][4];
  logic [15:0] ms [2][4], md [2][4];
  logic [1:0]  mp [2][4];
  logic [23:0] mo [2][4];

  function automatic int maxe(int d); return d ? 35 : 33; endfunction
  function automatic logic [35:0] wmask(int d); return d ? 36'h3_FFFF_FFFF : 36'hF_FFFF_FFFF; endfunction
  function automatic logic [35:0] amask(int d); return d ? 36'hF_FFFF_FFFF : 36'h3_FFFF_FFFF; endfunction

  task automatic mwrite(int d);
    int e = wr_enc;
    if (e < 11) e = 11;
    if (e > maxe(d)) e = maxe(d);
    mb[d][wr_idx] = wr_base & amask(d);
    mx[d][wr_idx] = wr_xlat & wmask(d);
    me[d][wr_idx] = e;
    men[d][wr_idx] = wr_ena;
    mm[d][wr_idx] = wr_maint && d == 1;
    mh[d][wr_idx] = wr_hops; ms[d][wr_idx] = wr_src; md[d][wr_idx] = wr_dst;
    mp[d][wr_idx] = wr_prio; mo[d][wr_idx] = wr_off;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int d = 0; d < 2; d++)
        for (int i = 0; i < 4; i++) begin
          mb[d][i] = 0; mx[d][i] = 0; me[d][i] = maxe(d); men[d][i] = (i == 0);
          mm[d][i] = 0; mh[d][i] = 0; ms[d][i] = 0; md[d][i] = 0; mp[d][i] = 0; mo[d][i] = 0;
        end
    end else begin
      if (wr_en_o) mwrite(1);
      if (wr_en_i) mwrite(0);
    end
  end

  task automatic mcmp(int d, bit h, int w, logic [35:0] o, bit m, logic [1:0] p,
                      logic [7:0] hp, logic [15:0] s, logic [15:0] dd, logic [23:0] off, bit err);
    logic [35:0] a = la & amask(d);
    logic [35:0] lm, eo;
    bit eh = 0; int sel = 0; bit ee;
    for (int i = 3; i >= 0; i--)
      if (men[d][i] && ((a >> (me[d][i] + 1)) == (mb[d][i] >> (me[d][i] + 1)))) begin
        eh = 1; sel = i;
      end
    lm = (36'd1 << (me[d][sel] + 1)) - 36'd1;
    if (me[d][sel] + 1 >= 36) lm = 36'hF_FFFF_FFFF;
    eo = ((mx[d][sel] & ~lm) | (a & lm)) & wmask(d);
    ee = (d ? wr_en_o : wr_en_i) && (wr_enc < 11 || wr_enc > maxe(d));
    checks++;
    if (h !== eh || w != sel || o !== eo || m !== mm[d][sel] || p !== mp[d][sel] ||
        hp !== mh[d][sel] || s !== ms[d][sel] || dd !== md[d][sel] || off !== mo[d][sel] || err !== ee) begin
      errors++;
      $display("FAIL %s dir%0d act hit=%0d win=%0d out=%h maint=%0d prio=%0d hops=%h src=%h dst=%h off=%h err=%0d exp hit=%0d win=%0d out=%h maint=%0d prio=%0d hops=%h src=%h dst=%h off=%h err=%0d",
               cur_req, d, h, w, o, m, p, hp, s, dd, off, err,
               eh, sel, eo, mm[d][sel], mp[d][sel], mh[d][sel], ms[d][sel], md[d][sel], mo[d][sel], ee);
    end
  endtask

  task automatic settle();
    #2;
    mcmp(1, o_hit, o_win, {2'b00, o_out}, o_maint, o_prio, o_hops, o_src, o_dst, o_off, o_err);
    mcmp(0, i_hit, i_win, i_out, i_maint, i_prio, i_hops, i_src, i_dst, i_off, i_err);
  endtask

  task automatic nxt();
    @(negedge clk);
    wr_en_o = 0; wr_en_i = 0;
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic setw(bit o, bit i, int idx, logic [35:0] b, logic [35:0] x, int e, bit en, bit mt,
                      logic [7:0] hp, logic [15:0] s, logic [15:0] dd, logic [1:0] p, logic [23:0] off);
    wr_en_o = o; wr_en_i = i; wr_idx = 2'(idx); wr_base = b; wr_xlat = x; wr_enc = 6'(e);
    wr_ena = en; wr_maint = mt; wr_hops = hp; wr_src = s; wr_dst = dd; wr_prio = p; wr_off = off;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R6 / R7: reset defaults
    la = 36'hB_1234_5678; settle();
    chk("R7 out", o_out, 34'h3_1234_5678);
    chk("R7 hit/win", {o_hit, o_win}, {1'b1, 2'd0});
    chk("R6 out", i_out, 36'h3_1234_5678);
    chk("R6 hit/win", {i_hit, i_win}, {1'b1, 2'd0});
    // R10: shrink outbound window 0; same cycle keeps old mapping
    nxt(); cur_req = "R10";
    setw(1, 0, 0, 0, 0, 11, 1, 0, 0, 0, 0, 0, 0);
    la = 36'h0_8000_1234; settle();
    chk("R10 old mapping", {o_hit, o_out}, {1'b1, 34'h0_8000_1234});
    nxt(); cur_req = "R1"; settle();
    chk("R1 miss", {o_hit, o_win, o_out}, {1'b0, 2'd0, 34'h0_0000_0234});
    // R4 / R11: window 1
    nxt(); cur_req = "R11";
    setw(1, 0, 1, 36'h0_8000_0000, 36'h2_0000_0000, 15, 1, 0, 8'h5, 16'h1, 16'h2, 2'd2, 24'h7);
    settle(); nxt(); settle();
    chk("R4 out", o_out, 34'h2_0000_1234);
    chk("R11 win/prio/hops", {o_hit, o_win, o_prio, o_hops}, {1'b1, 2'd1, 2'd2, 8'h5});
    // R2: overlapping window 2
    nxt(); cur_req = "R2";
    setw(1, 0, 2, 36'h0_8000_0000, 36'h1_0000_0000, 19, 1, 0, 8'h6, 16'h3, 16'h4, 2'd1, 24'h8);
    settle(); nxt(); settle();
    chk("R2 lowest wins", {o_win, o_out}, {2'd1, 34'h2_0000_1234});
    nxt(); la = 36'h0_8008_0000; settle();
    chk("R2 outer only", {o_win, o_out, o_prio}, {2'd2, 34'h1_0008_0000, 2'd1});
    // R9: disable window 1
    nxt(); cur_req = "R9";
    setw(1, 0, 1, 36'h0_8000_0000, 36'h2_0000_0000, 15, 0, 0, 8'h5, 16'h1, 16'h2, 2'd2, 24'h7);
    la = 36'h0_8000_1234; settle(); nxt(); settle();
    chk("R9 disabled skipped", {o_win, o_out}, {2'd2, 34'h1_0000_1234});
    // R8: maintenance window 3, both directions
    nxt(); cur_req = "R8";
    setw(1, 1, 3, 36'h1_0000_0000, 0, 23, 1, 1, 8'h3, 16'h0011, 16'h0022, 2'd3, 24'hABC);
    settle(); nxt(); la = 36'h1_0012_3456; settle();
    chk("R8 maint out", {o_hit, o_win, o_maint, o_out}, {1'b1, 2'd3, 1'b1, 34'h0_0012_3456});
    chk("R8 routing", {o_hops, o_src, o_dst, o_off}, {8'h3, 16'h0011, 16'h0022, 24'hABC});
    chk("R8 inbound no maint", i_maint, 1'b0);
    // R3: clamping
    nxt(); cur_req = "R3";
    setw(1, 1, 3, 36'h1_0000_0000, 0, 5, 1, 1, 8'h3, 16'h0011, 16'h0022, 2'd3, 24'hABC);
    settle();
    chk("R3 err low", {o_err, i_err}, 2'b11);
    nxt(); la = 36'h1_0000_1000; settle();
    chk("R3 clamp to 4K", o_hit, 1'b0);
    nxt();
    setw(1, 1, 3, 36'h1_0000_0000, 0, 40, 1, 1, 8'h3, 16'h0011, 16'h0022, 2'd3, 24'hABC);
    settle();
    chk("R3 err high", {o_err, i_err}, 2'b11);
    nxt(); la = 36'hF_0000_0000; settle();
    chk("R3 clamp to 64G", {o_win, o_out}, {2'd3, 34'h3_0000_0000});
    nxt();
    setw(1, 0, 2, 36'h0_8000_0000, 36'h1_0000_0000, 11, 1, 0, 0, 0, 0, 0, 0);
    settle();
    chk("R3 legal no err", o_err, 1'b0);
    // R5: inbound translation
    nxt(); cur_req = "R5";
    setw(0, 1, 0, 0, 0, 11, 0, 0, 0, 0, 0, 0, 0);
    settle(); nxt();
    setw(0, 1, 1, 36'h0_4000_0000, 36'h9_0000_0000, 13, 1, 0, 0, 0, 0, 0, 0);
    settle(); nxt(); la = 36'h0_4000_2ABC; settle();
    chk("R5 inbound widen", {i_hit, i_win, i_out}, {1'b1, 2'd1, 36'h9_0000_2ABC});
    // random phase against model
    cur_req = "R2";
    for (int n = 0; n < 600; n++) begin
      nxt();
      if ($urandom_range(3) == 0)
        setw($urandom_range(1), $urandom_range(1), $urandom_range(3),
             {$urandom_range(15), 20'h0, 12'($urandom)} & 36'hF_FFF0_0000 | 36'({$urandom} & 32'hFFF0_0000),
             {4'($urandom), 32'($urandom)}, $urandom_range(8, 38), $urandom_range(3) != 0,
             $urandom_range(1), 8'($urandom), 16'($urandom), 16'($urandom), 2'($urandom), 24'($urandom));
      la = {4'($urandom), 32'($urandom)};
      if ($urandom_range(1)) la[35:20] = wr_base[35:20];
      settle();
    end
    nxt();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule